// File: doc/BRIEF.md
# Multi-Game Vector ROM Bank Selector

This block is the glue between a CPU bus and the two ROMs of a board that carries several games. It drives the active-low output enable of the program ROM from address bit 15. It drives the active-low output enable of a 32K vector ROM from the vector engine's ROM/RAM select, passed through an exclusive-OR whose second leg is a polarity control. It also holds an 8-bit bank register, and the two low bits of that register choose which 8K window of the vector ROM the vector engine sees.

Any CPU memory write to the upper half of the address space (address bit 15 high) loads the data bus into the bank register. The block runs from a system clock. It samples the write strobe and does not clock the register from a gated strobe. Two strobe forms are available. In edge mode, a load needs a falling write strobe while bit 15 is high. In combined mode, a load happens when the NOR of the write strobe and inverted bit 15 rises. Combined mode tolerates an address that settles after the strobe.

Top module: `bank_glue`

## Requirements
- R1: `prog_oe_n` is the inverse of `cpu_a15` at all times, with no clock delay.
- R2: `vrom_oe_n` equals `rom_sel` XOR `oe_pol` at all times, with no clock delay.
- R3: `vrom_bank` carries bank register bits 1:0. Output bit 1 drives vector ROM address 14 and bit 0 drives address 13. The upper six stored bits have no effect on any output.
- R4: While `rst_n` is low, the bank register clears to zero, which selects vector ROM bank 0.
- R5: With `strobe_mode`=0, the register loads `cpu_d` at the clock edge where `mem_wr_n` is sampled low after being sampled high on the previous edge, provided `cpu_a15` is high at that edge. The new value appears on `vrom_bank` after that edge.
- R6: A cycle with `cpu_a15` low, or with `mem_wr_n` high (a read or an idle cycle), leaves the bank register unchanged in both modes.
- R7: With `strobe_mode`=0, a strobe that is already low when `cpu_a15` rises does not load. A strobe held low loads only once, even if `cpu_d` changes while it stays low.
- R8: With `strobe_mode`=1, the register loads `cpu_d` at the first edge where `cpu_a15` is high and `mem_wr_n` is low, after an edge where that was not true. This includes `cpu_a15` rising while the strobe is already low. Each such interval loads only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpu_a15 | input | 1 | CPU address bit 15 |
| cpu_d | input | 8 | CPU data bus |
| mem_wr_n | input | 1 | Active-low memory write strobe |
| rom_sel | input | 1 | Vector engine ROM/RAM output select |
| oe_pol | input | 1 | Polarity control for the vector ROM enable XOR |
| strobe_mode | input | 1 | 0 = edge mode, 1 = combined NOR mode |
| prog_oe_n | output | 1 | Program ROM output enable, active low |
| vrom_bank | output | 2 | Vector ROM address bits 14:13 |
| vrom_oe_n | output | 1 | Vector ROM output enable, active low |

## Verification
The hardest case to bring about is the order of events around the strobe. The address bit can rise while the write strobe is already held low, and the data can change during one long strobe. In that case the two modes must disagree: one loads and the other does not. The stimulus holds `mem_wr_n` low across several clock edges, raises `cpu_a15` part way through, and then changes `cpu_d`. It runs this sequence once in each mode. A full sweep of all 256 data values, written both above and below the boundary, covers the bank decode and the ignored writes.

// File: rtl/bank_glue.sv
module bank_glue #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_a15,
  input  logic [DATA_W-1:0] cpu_d,
  input  logic              mem_wr_n,
  input  logic              rom_sel,
  input  logic              oe_pol,
  input  logic              strobe_mode,
  output logic              prog_oe_n,
  output logic [SEL_W-1:0]  vrom_bank,
  output logic              vrom_oe_n
);

  logic [DATA_W-1:0] bank;
  logic              wr_q;
  logic              stb_q;
  logic              stb;
  logic              load;

  assign prog_oe_n = ~cpu_a15;
  assign vrom_oe_n = rom_sel ^ oe_pol;
  assign stb       = ~(mem_wr_n | ~cpu_a15);

  always_comb begin
    if (strobe_mode) load = stb & ~stb_q;
    else             load = cpu_a15 & wr_q & ~mem_wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      stb_q <= 1'b0;
      bank  <= '0;
    end else begin
      wr_q  <= mem_wr_n;
      stb_q <= stb;
      if (load) bank <= cpu_d;
    end
  end

  assign vrom_bank = bank[SEL_W-1:0];

  a_r6_low_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_a15 |=> $stable(bank));

  a_r6_no_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_n |=> $stable(bank));

  a_r7_held_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_mode && !wr_q) |=> $stable(bank));

  a_r5_edge_loads_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_mode && cpu_a15 && wr_q && !mem_wr_n) |=> (bank == $past(cpu_d)));

  a_r8_nor_held_once: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_mode && stb_q) |=> $stable(bank));

endmodule

// File: tb/bank_glue_bench.sv
module bank_glue_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cpu_a15, mem_wr_n, rom_sel, oe_pol, strobe_mode;
  logic [7:0] cpu_d;
  logic       prog_oe_n, vrom_oe_n;
  logic [1:0] vrom_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  bank_glue u_bank_glue (
    .clk(clk), .rst_n(rst_n), .cpu_a15(cpu_a15), .cpu_d(cpu_d),
    .mem_wr_n(mem_wr_n), .rom_sel(rom_sel), .oe_pol(oe_pol),
    .strobe_mode(strobe_mode), .prog_oe_n(prog_oe_n),
    .vrom_bank(vrom_bank), .vrom_oe_n(vrom_oe_n));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); cpu_a15 = a; cpu_d = d; mem_wr_n = 1'b0;
    @(negedge clk); mem_wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cpu_a15 = 0; mem_wr_n = 1; rom_sel = 0; oe_pol = 0;
    strobe_mode = 0; cpu_d = 8'h00;
    repeat (3) @(negedge clk);
    chk("R4 reset bank", vrom_bank, 0);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 2; a++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++) begin
          cpu_a15 = a[0]; rom_sel = s[0]; oe_pol = p[0];
          #1;
          chk("R1 prog_oe_n", prog_oe_n, 1 - a);
          chk("R2 vrom_oe_n", vrom_oe_n, s ^ p);
        end

    for (int m = 0; m < 2; m++) begin
      strobe_mode = m[0];
      for (int d = 0; d < 256; d++) begin
        wr(1'b1, d[7:0]);
        chk($sformatf("R3 R5 R8 bank mode%0d d%0d", m, d), vrom_bank, d % 4);
      end
      wr(1'b1, 8'h02);
      for (int d = 0; d < 256; d++) begin
        wr(1'b0, d[7:0]);
        chk("R6 low write ignored", vrom_bank, 2);
      end
      @(negedge clk); cpu_a15 = 1; cpu_d = 8'h01;
      repeat (3) @(negedge clk);
      chk("R6 read ignored", vrom_bank, 2);
    end

    strobe_mode = 0; wr(1'b1, 8'h00);
    @(negedge clk); cpu_a15 = 0; cpu_d = 8'h03; mem_wr_n = 0;
    repeat (2) @(negedge clk);
    cpu_a15 = 1;
    repeat (2) @(negedge clk);
    chk("R7 late a15 no load", vrom_bank, 0);
    mem_wr_n = 1; @(negedge clk);
    mem_wr_n = 0; cpu_d = 8'h02;
    @(negedge clk);
    chk("R5 edge load", vrom_bank, 2);
    cpu_d = 8'h01;
    repeat (2) @(negedge clk);
    chk("R7 held strobe once", vrom_bank, 2);
    mem_wr_n = 1; @(negedge clk);

    strobe_mode = 1; wr(1'b1, 8'h00);
    @(negedge clk); cpu_a15 = 0; cpu_d = 8'h03; mem_wr_n = 0;
    repeat (2) @(negedge clk);
    chk("R8 a15 low no load", vrom_bank, 0);
    cpu_a15 = 1;
    @(negedge clk);
    chk("R8 late a15 loads", vrom_bank, 3);
    cpu_d = 8'h01;
    repeat (2) @(negedge clk);
    chk("R8 held once", vrom_bank, 3);
    mem_wr_n = 1; @(negedge clk);

    wr(1'b1, 8'hFE);
    chk("R3 upper bits ignored", vrom_bank, 2);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R4 reset clears", vrom_bank, 0);
    rst_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule